// File: doc/BRIEF.md
# Flash Command Sequence Decoder

The decoder sits beside a flash controller's bus port and watches store cycles that fall inside the flash address window. Every such store is a command cycle. The decoder checks it against the sequence in progress, using the low 16 address bits and the write data. A complete sequence produces a one-cycle command strobe, registered one clock after the completing store. The strobe carries a command type, the sector or page field taken from address bits 21:16, and any password or program data.

There are two kinds of sequence. Some commands finish in one store with no unlock prefix. Erase, page write and protection release need an unlock pair first, followed by a final opcode or password cycle. A store that fits no legal next step aborts the sequence and sets a sticky error flag. Reads and stores outside the window are not command cycles and leave everything untouched. A busy bit marks array operations in flight until the array reports completion.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A command cycle is a cycle with bus_valid=1, bus_write=1 and bus_addr[31:22] equal to WIN_BASE (default 0x2A0). Reads and stores outside the window change neither the sequence state, the strobe nor the error flag.
- R2: From idle, these single stores issue a command. At low address 0x5554, opcode wdata[7:0]=0xF0 gives type 1 (reset), 0xF5 gives type 2 (clear status) and 0x50 gives type 4 (page mode, with sector field set). A store to low address 0x55F0 gives type 3 (load), with cmd_data equal to the full 64-bit write data.
- R3: The unlock pair is low address 0x5554 with opcode 0xAA, then low address 0xAAA8 with opcode 0x55. Address bits 21:16 are ignored in both unlock cycles.
- R4: After the unlock pair, the final cycle can be one of three stores. Low address 0x0000 with opcode 0x30 gives type 5 (sector erase). Low address 0x00AA with opcode 0xA0 gives type 6 (page write). Low address 0x5558 gives type 7 (protection release), with cmd_data equal to zero-extended wdata[31:0].
- R5: cmd_valid is high for exactly the one cycle after the completing store. cmd_sect equals bus_addr[21:16] for types 4, 5 and 6 and is zero for all other types. cmd_data is zero for all types except 3 and 7.
- R6: A command cycle that is not a legal next step sets stat_err one cycle later and issues no strobe. The decoder returns to idle, and the offending store is not taken as the first cycle of a new sequence.
- R7: stat_err stays set until clr_i is high or a type-2 command completes. If an error and clr_i fall in the same cycle, the error wins.
- R8: stat_busy is set together with a type-5 or type-6 strobe. It clears one cycle after done_i is high. If a set and done_i fall in the same cycle, the set wins.
- R9: After reset the decoder is idle, with cmd_valid, stat_err and stat_busy all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_write | input | 1 | Bus cycle is a store |
| bus_addr | input | 32 | Bus byte address |
| bus_wdata | input | 64 | Store data |
| done_i | input | 1 | Array operation finished |
| clr_i | input | 1 | Clear the error flag |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_type | output | 4 | Command type code |
| cmd_sect | output | 6 | Sector/page field |
| cmd_data | output | 64 | Password or program data |
| stat_err | output | 1 | Sticky sequence error |
| stat_busy | output | 1 | Array operation in flight |

## Verification
The hardest cases to reach are the ones where the port behaviour depends on the hidden sequence state. Examples are a repeated first unlock store, or an unlock pair broken by a read or an out-of-window store. The stimulus reaches these states by issuing partial unlock sequences, then following them with a single probe store. The result shows whether the interrupting cycle was treated as a command. A second probe, issued after clearing the flag, confirms that the decoder restarted from idle rather than from the aborted step. Same-cycle races between error and clear, and between busy set and done, are forced by raising the side input during the very store that completes or breaks a sequence.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_UNL1, K_UNL2, K_RESET, K_CLRST, K_LOAD,
    K_PGMODE, K_ERASE, K_WRPAGE, K_UNPROT, K_BAD
  } kind_e;

  typedef enum logic [1:0] {S_IDLE, S_UNL1, S_UNL2} seq_e;

  localparam logic [3:0] CT_NONE   = 4'd0;
  localparam logic [3:0] CT_RESET  = 4'd1;
  localparam logic [3:0] CT_CLRST  = 4'd2;
  localparam logic [3:0] CT_LOAD   = 4'd3;
  localparam logic [3:0] CT_PGMODE = 4'd4;
  localparam logic [3:0] CT_ERASE  = 4'd5;
  localparam logic [3:0] CT_WRPAGE = 4'd6;
  localparam logic [3:0] CT_UNPROT = 4'd7;

  localparam logic [15:0] LA_MAIN   = 16'h5554;
  localparam logic [15:0] LA_ALT    = 16'hAAA8;
  localparam logic [15:0] LA_LOAD   = 16'h55F0;
  localparam logic [15:0] LA_SECTOR = 16'h0000;
  localparam logic [15:0] LA_PAGE   = 16'h00AA;
  localparam logic [15:0] LA_PASS   = 16'h5558;

  localparam logic [7:0] OP_UNL1   = 8'hAA;
  localparam logic [7:0] OP_UNL2   = 8'h55;
  localparam logic [7:0] OP_RESET  = 8'hF0;
  localparam logic [7:0] OP_CLRST  = 8'hF5;
  localparam logic [7:0] OP_PGMODE = 8'h50;
  localparam logic [7:0] OP_ERASE  = 8'h30;
  localparam logic [7:0] OP_WRPAGE = 8'hA0;

  function automatic logic kind_single(input kind_e k);
    return (k == K_RESET) || (k == K_CLRST) || (k == K_LOAD) || (k == K_PGMODE);
  endfunction

  function automatic logic kind_final(input kind_e k);
    return (k == K_ERASE) || (k == K_WRPAGE) || (k == K_UNPROT);
  endfunction

  function automatic logic [3:0] kind_to_ct(input kind_e k);
    case (k)
      K_RESET:  return CT_RESET;
      K_CLRST:  return CT_CLRST;
      K_LOAD:   return CT_LOAD;
      K_PGMODE: return CT_PGMODE;
      K_ERASE:  return CT_ERASE;
      K_WRPAGE: return CT_WRPAGE;
      K_UNPROT: return CT_UNPROT;
      default:  return CT_NONE;
    endcase
  endfunction

  function automatic logic is_array(input logic [3:0] ct);
    return (ct == CT_ERASE) || (ct == CT_WRPAGE);
  endfunction

  function automatic logic has_sect(input logic [3:0] ct);
    return (ct == CT_PGMODE) || (ct == CT_ERASE) || (ct == CT_WRPAGE);
  endfunction

endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import fcd_pkg::*;
#(
  parameter int HI_W   = 10,
  parameter int CMD_AW = 16,
  parameter logic [HI_W-1:0] WIN_BASE = '0
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [HI_W-1:0]   addr_hi,
  input  logic [CMD_AW-1:0] addr_lo,
  input  logic [7:0]        opcode,
  output logic              cyc_cmd,
  output kind_e             cyc_kind
);

  assign cyc_cmd = bus_valid && bus_write && (addr_hi == WIN_BASE);

  always_comb begin
    cyc_kind = K_NONE;
    if (cyc_cmd) begin
      cyc_kind = K_BAD;
      if (addr_lo == CMD_AW'(LA_MAIN)) begin
        if (opcode == OP_UNL1)        cyc_kind = K_UNL1;
        else if (opcode == OP_RESET)  cyc_kind = K_RESET;
        else if (opcode == OP_CLRST)  cyc_kind = K_CLRST;
        else if (opcode == OP_PGMODE) cyc_kind = K_PGMODE;
      end else if (addr_lo == CMD_AW'(LA_ALT)) begin
        if (opcode == OP_UNL2) cyc_kind = K_UNL2;
      end else if (addr_lo == CMD_AW'(LA_LOAD)) begin
        cyc_kind = K_LOAD;
      end else if (addr_lo == CMD_AW'(LA_SECTOR)) begin
        if (opcode == OP_ERASE) cyc_kind = K_ERASE;
      end else if (addr_lo == CMD_AW'(LA_PAGE)) begin
        if (opcode == OP_WRPAGE) cyc_kind = K_WRPAGE;
      end else if (addr_lo == CMD_AW'(LA_PASS)) begin
        cyc_kind = K_UNPROT;
      end
    end
  end

endmodule

// File: rtl/fcd_seq_fsm.sv
module fcd_seq_fsm
  import fcd_pkg::*;
#(
  parameter int SECT_W = 6,
  parameter int DATA_W = 64,
  parameter int PASS_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_cmd,
  input  kind_e             cyc_kind,
  input  logic [SECT_W-1:0] sect_in,
  input  logic [DATA_W-1:0] wdata,
  output logic              cmd_valid,
  output logic [3:0]        cmd_type,
  output logic [SECT_W-1:0] cmd_sect,
  output logic [DATA_W-1:0] cmd_data,
  output logic              err_evt,
  output logic              clr_evt,
  output logic              arr_evt,
  output logic              seq_idle
);

  seq_e        state, nxt;
  logic        strobe_n, err_n;
  logic [3:0]  ct_n;
  logic [DATA_W-1:0] data_n;

  always_comb begin
    nxt      = state;
    strobe_n = 1'b0;
    err_n    = 1'b0;
    if (cyc_cmd) begin
      unique case (state)
        S_IDLE: begin
          if (cyc_kind == K_UNL1)        nxt = S_UNL1;
          else if (kind_single(cyc_kind)) strobe_n = 1'b1;
          else                            err_n = 1'b1;
        end
        S_UNL1: begin
          if (cyc_kind == K_UNL2) nxt = S_UNL2;
          else begin
            err_n = 1'b1;
            nxt   = S_IDLE;
          end
        end
        S_UNL2: begin
          nxt = S_IDLE;
          if (kind_final(cyc_kind)) strobe_n = 1'b1;
          else                      err_n = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  assign ct_n = kind_to_ct(cyc_kind);

  always_comb begin
    data_n = '0;
    if (ct_n == CT_LOAD)        data_n = wdata;
    else if (ct_n == CT_UNPROT) data_n = {{(DATA_W-PASS_W){1'b0}}, wdata[PASS_W-1:0]};
  end

  assign err_evt  = err_n;
  assign clr_evt  = strobe_n && (ct_n == CT_CLRST);
  assign arr_evt  = strobe_n && is_array(ct_n);
  assign seq_idle = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_valid <= 1'b0;
      cmd_type  <= CT_NONE;
      cmd_sect  <= '0;
      cmd_data  <= '0;
    end else begin
      state     <= nxt;
      cmd_valid <= strobe_n;
      cmd_type  <= strobe_n ? ct_n : CT_NONE;
      cmd_sect  <= (strobe_n && has_sect(ct_n)) ? sect_in : '0;
      cmd_data  <= strobe_n ? data_n : '0;
    end
  end

endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic clk,
  input  logic rst_n,
  input  logic err_evt,
  input  logic clr_evt,
  input  logic clr_i,
  input  logic arr_evt,
  input  logic done_i,
  output logic stat_err,
  output logic stat_busy
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_err  <= 1'b0;
      stat_busy <= 1'b0;
    end else begin
      if (err_evt)               stat_err <= 1'b1;
      else if (clr_i || clr_evt) stat_err <= 1'b0;
      if (arr_evt)     stat_busy <= 1'b1;
      else if (done_i) stat_busy <= 1'b0;
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CMD_AW = 16,
  parameter int SECT_W = 6,
  parameter int PASS_W = 32,
  parameter logic [ADDR_W-CMD_AW-SECT_W-1:0] WIN_BASE = 10'h2A0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              done_i,
  input  logic              clr_i,
  output logic              cmd_valid,
  output logic [3:0]        cmd_type,
  output logic [SECT_W-1:0] cmd_sect,
  output logic [DATA_W-1:0] cmd_data,
  output logic              stat_err,
  output logic              stat_busy
);

  localparam int LOW_W = CMD_AW + SECT_W;
  localparam int HI_W  = ADDR_W - LOW_W;

  logic  cyc_cmd;
  kind_e cyc_kind;
  logic  err_evt, clr_evt, arr_evt, seq_idle;

  fcd_classify #(.HI_W(HI_W), .CMD_AW(CMD_AW), .WIN_BASE(WIN_BASE)) u_cls (
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .addr_hi   (bus_addr[ADDR_W-1:LOW_W]),
    .addr_lo   (bus_addr[CMD_AW-1:0]),
    .opcode    (bus_wdata[7:0]),
    .cyc_cmd   (cyc_cmd),
    .cyc_kind  (cyc_kind)
  );

  fcd_seq_fsm #(.SECT_W(SECT_W), .DATA_W(DATA_W), .PASS_W(PASS_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_cmd   (cyc_cmd),
    .cyc_kind  (cyc_kind),
    .sect_in   (bus_addr[LOW_W-1:CMD_AW]),
    .wdata     (bus_wdata),
    .cmd_valid (cmd_valid),
    .cmd_type  (cmd_type),
    .cmd_sect  (cmd_sect),
    .cmd_data  (cmd_data),
    .err_evt   (err_evt),
    .clr_evt   (clr_evt),
    .arr_evt   (arr_evt),
    .seq_idle  (seq_idle)
  );

  fcd_status u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_evt   (err_evt),
    .clr_evt   (clr_evt),
    .clr_i     (clr_i),
    .arr_evt   (arr_evt),
    .done_i    (done_i),
    .stat_err  (stat_err),
    .stat_busy (stat_busy)
  );

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
  import fcd_pkg::*;
#(
  parameter int SECT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              done_i,
  input logic              clr_i,
  input logic              cmd_valid,
  input logic [3:0]        cmd_type,
  input logic [SECT_W-1:0] cmd_sect,
  input logic              stat_err,
  input logic              stat_busy,
  input logic              err_evt,
  input logic              clr_evt,
  input logic              arr_evt,
  input logic              seq_idle
);

  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write) |=> !cmd_valid); // R1

  AST_SECT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !has_sect(cmd_type)) |-> (cmd_sect == '0)); // R5

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> (!cmd_valid && stat_err && seq_idle)); // R6

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_err && !clr_i && !clr_evt) |=> stat_err); // R7

  AST_CLR_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !stat_err); // R7

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && is_array(cmd_type)) |-> stat_busy); // R8

  AST_BUSY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !arr_evt) |=> !stat_busy); // R8

endmodule

bind flash_cmd_decoder fcd_chk #(.SECT_W(SECT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .done_i    (done_i),
  .clr_i     (clr_i),
  .cmd_valid (cmd_valid),
  .cmd_type  (cmd_type),
  .cmd_sect  (cmd_sect),
  .stat_err  (stat_err),
  .stat_busy (stat_busy),
  .err_evt   (err_evt),
  .clr_evt   (clr_evt),
  .arr_evt   (arr_evt),
  .seq_idle  (seq_idle)
);

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] WB = 10'h2A0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic        done_i = 1'b0, clr_i = 1'b0;
  logic        cmd_valid;
  logic [3:0]  cmd_type;
  logic [5:0]  cmd_sect;
  logic [63:0] cmd_data;
  logic        stat_err, stat_busy;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .done_i(done_i), .clr_i(clr_i),
    .cmd_valid(cmd_valid), .cmd_type(cmd_type), .cmd_sect(cmd_sect),
    .cmd_data(cmd_data), .stat_err(stat_err), .stat_busy(stat_busy)
  );

  function automatic logic [31:0] fa(input logic [5:0] s, input logic [15:0] lo);
    return {WB, s, lo};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic wr, input logic [31:0] a, input logic [63:0] d,
                     input logic clr = 1'b0, input logic dn = 1'b0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    clr_i = clr; done_i = dn;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; clr_i = 1'b0; done_i = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done_i = 1'b1;
    @(negedge clk); done_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  task automatic unlock(input logic [5:0] s1, input logic [5:0] s2);
    cyc(1'b1, fa(s1, 16'h5554), 64'hAA);
    cyc(1'b1, fa(s2, 16'hAAA8), 64'h55);
  endtask

  task automatic expect_cmd(input string req, input logic [3:0] t,
                            input logic [5:0] s, input logic [63:0] d);
    chk({req, " valid"}, 64'(cmd_valid), 64'd1);
    chk({req, " type"}, 64'(cmd_type), 64'(t));
    chk({req, " sect"}, 64'(cmd_sect), 64'(s));
    chk({req, " data"}, cmd_data, d);
  endtask

  task automatic t_reset();
    chk("R9 valid", 64'(cmd_valid), 64'd0);
    chk("R9 err", 64'(stat_err), 64'd0);
    chk("R9 busy", 64'(stat_busy), 64'd0);
  endtask

  task automatic t_single();
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hF0);
    expect_cmd("R2 reset", 4'd1, 6'h00, 64'd0);
    @(negedge clk);
    chk("R5 one-cycle strobe", 64'(cmd_valid), 64'd0);
    cyc(1'b1, fa(6'h2B, 16'h5554), 64'h50);
    expect_cmd("R2 page mode", 4'd4, 6'h2B, 64'd0);
    cyc(1'b1, fa(6'h11, 16'h55F0), 64'hDEAD_BEEF_0123_4567);
    expect_cmd("R2 R5 load", 4'd3, 6'h00, 64'hDEAD_BEEF_0123_4567);
    chk("R2 no err", 64'(stat_err), 64'd0);
  endtask

  task automatic t_erase();
    cyc(1'b1, fa(6'h3F, 16'h5554), 64'hAA);
    chk("R3 unlock1 no strobe", 64'(cmd_valid), 64'd0);
    chk("R3 unlock1 no err", 64'(stat_err), 64'd0);
    cyc(1'b1, fa(6'h15, 16'hAAA8), 64'h55);
    chk("R3 unlock2 no err", 64'(stat_err), 64'd0);
    cyc(1'b1, fa(6'h07, 16'h0000), 64'h30);
    expect_cmd("R4 erase", 4'd5, 6'h07, 64'd0);
    chk("R8 busy set", 64'(stat_busy), 64'd1);
    pulse_done();
    chk("R8 busy cleared", 64'(stat_busy), 64'd0);
  endtask

  task automatic t_page_pass();
    unlock(6'h00, 6'h00);
    cyc(1'b1, fa(6'h22, 16'h00AA), 64'hA0);
    expect_cmd("R4 page write", 4'd6, 6'h22, 64'd0);
    pulse_done();
    unlock(6'h01, 6'h02);
    cyc(1'b1, fa(6'h09, 16'h5558), 64'hFFFF_FFFF_1234_5678);
    expect_cmd("R4 R5 password", 4'd7, 6'h00, 64'h0000_0000_1234_5678);
    chk("R8 no busy for password", 64'(stat_busy), 64'd0);
  endtask

  task automatic t_ignore();
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hAA);
    cyc(1'b0, fa(6'h00, 16'h0000), 64'h30);
    chk("R1 read no strobe", 64'(cmd_valid), 64'd0);
    cyc(1'b1, {~WB, 6'h00, 16'hAAA8}, 64'h77);
    chk("R1 outside write no err", 64'(stat_err), 64'd0);
    cyc(1'b1, fa(6'h00, 16'hAAA8), 64'h55);
    cyc(1'b1, fa(6'h0C, 16'h0000), 64'h30);
    expect_cmd("R1 sequence survived", 4'd5, 6'h0C, 64'd0);
    pulse_done();
  endtask

  task automatic t_errors();
    cyc(1'b1, fa(6'h00, 16'h0000), 64'h30);
    chk("R6 final in idle err", 64'(stat_err), 64'd1);
    chk("R6 no strobe", 64'(cmd_valid), 64'd0);
    pulse_clr();
    chk("R7 clr_i clears", 64'(stat_err), 64'd0);
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hAA);
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hAA);
    chk("R6 repeated unlock1 err", 64'(stat_err), 64'd1);
    pulse_clr();
    cyc(1'b1, fa(6'h00, 16'hAAA8), 64'h55);
    chk("R6 offending store not restart", 64'(stat_err), 64'd1);
    pulse_clr();
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hAA);
    cyc(1'b1, fa(6'h00, 16'hAAA8), 64'h56);
    chk("R6 bad unlock2 data", 64'(stat_err), 64'd1);
    pulse_clr();
    unlock(6'h00, 6'h00);
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hF0);
    chk("R6 single inside sequence err", 64'(stat_err), 64'd1);
    chk("R6 single inside sequence no strobe", 64'(cmd_valid), 64'd0);
  endtask

  task automatic t_sticky();
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hF0);
    expect_cmd("R7 command with err set", 4'd1, 6'h00, 64'd0);
    chk("R7 err held", 64'(stat_err), 64'd1);
    cyc(1'b1, fa(6'h00, 16'h5554), 64'hF5);
    expect_cmd("R2 clear status", 4'd2, 6'h00, 64'd0);
    chk("R7 clear cmd clears", 64'(stat_err), 64'd0);
    cyc(1'b1, fa(6'h00, 16'h1234), 64'h00, 1'b1);
    chk("R7 error wins over clr_i", 64'(stat_err), 64'd1);
    pulse_clr();
    chk("R7 cleared again", 64'(stat_err), 64'd0);
  endtask

  task automatic t_busy_race();
    unlock(6'h00, 6'h00);
    cyc(1'b1, fa(6'h05, 16'h0000), 64'h30, 1'b0, 1'b1);
    expect_cmd("R8 erase with done", 4'd5, 6'h05, 64'd0);
    chk("R8 set wins over done", 64'(stat_busy), 64'd1);
    pulse_done();
    chk("R8 done clears", 64'(stat_busy), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_erase();
    t_page_pass();
    t_ignore();
    t_errors();
    t_sticky();
    t_busy_race();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule